// File: doc/BRIEF.md
# Dead-Time Half-Bridge Gate Sequencer

This block drives the two gates of a half-bridge from a single system clock. It takes a half-period length in clock cycles and produces complementary high-side and low-side gate signals of equal width. Each half-period has two parts: an on-phase and then a dead phase in which both gates are low, so the two switches never conduct together. The dead time is fixed at build time by choosing one of two device variants, either 1.8 us or 1.0 us. It is turned into clock cycles from the clock frequency parameter.

The supervisory logic (supply monitor, fault latch) drives a single enable input. Whenever enable is low, both gates are held low from the next clock edge onward. Every run that starts from the disabled state begins with a low-side pulse, so that the bootstrap capacitor feeding the high-side driver is charged before the high side ever switches. A one-clock strobe marks each rising edge of the low-side gate, so the current-sensing logic can start its blanking and zero-crossing timing from it.

A new half-period value is taken only at the start of a low-side pulse. A change in the middle of a cycle therefore never produces a short or uneven pulse.

Top module: `hb_gate_seq`

## Requirements
- R1: While and after a synchronous reset, with enable low, `hs_gate`, `ls_gate` and `ls_rise` are all 0.
- R2: While `en` is low, both gates and the strobe stay 0 whatever value `half_per` holds.
- R3: Suppose `en` is sampled high at an edge while the block is idle. From that edge on, `ls_gate` is 1 and `hs_gate` stays 0 until the first low-side pulse and its dead phase are complete. The high side is never the first gate to switch after enable.
- R4: Between the end of each on-pulse and the start of the next pulse on the other gate, both gates are 0 for exactly DEAD cycles. DEAD is round(CLK_MHZ*1.8) when `SLOW_DEAD`=1 and CLK_MHZ when `SLOW_DEAD`=0.
- R5: With a half-period H (in clock cycles) latched, the sequence repeats every 2*H cycles as: `ls_gate` high for H-DEAD cycles, DEAD dead cycles, `hs_gate` high for H-DEAD cycles, DEAD dead cycles. Both gates therefore have the same width.
- R6: `hs_gate` and `ls_gate` are never 1 in the same clock cycle.
- R7: If `en` is sampled low at any point of a running cycle, both gates are 0 from that edge on.
- R8: `half_per` is sampled only at the edge that starts a low-side pulse, and the value sampled there governs the whole 2*H cycle. A change at any other time takes effect at the next low-side start.
- R9: `ls_rise` is 1 for exactly the clock cycles in which `ls_gate` is 1 and was 0 in the previous cycle.
- R10: A `half_per` below DEAD+1 is treated as DEAD+1, which gives one-cycle on-pulses with the full dead time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low during undervoltage or fault |
| half_per | input | PER_W | Half-period length in clock cycles |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| ls_rise | output | 1 | One-cycle strobe on each low-side rising edge |

## Verification
The bench builds two instances with CLK_MHZ=5. One has SLOW_DEAD=1, which gives a dead time of 9 cycles; the other has SLOW_DEAD=0, which gives 5 cycles. Both are driven with the same stimulus, so each dead-time variant is checked, and a whole period takes only tens of cycles. With these short dead times, the bench can reach the case where a requested half-period falls below the minimum for one variant but not the other, as well as mid-cycle period changes and disables at arbitrary phases. Every run is compared cycle by cycle against an independent waveform model.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_LS_ON = 3'd1,
    PH_GAP_A = 3'd2,
    PH_HS_ON = 3'd3,
    PH_GAP_B = 3'd4
  } phase_t;

  // dead time in clock cycles: 1.8 us (rounded) or 1.0 us
  function automatic int dead_cycles(input int clk_mhz, input bit slow);
    if (slow) return (clk_mhz * 18 + 5) / 10;
    return clk_mhz;
  endfunction

endpackage

// File: rtl/hb_len_calc.sv
module hb_len_calc #(
  parameter int PER_W = 16,
  parameter int DEAD  = 9
) (
  input  logic [PER_W-1:0] raw_half,
  output logic [PER_W-1:0] half_c,
  output logic [PER_W-1:0] on_m1
);
  localparam logic [PER_W-1:0] MIN_HALF = PER_W'(DEAD + 1);

  always_comb begin
    half_c = (raw_half < MIN_HALF) ? MIN_HALF : raw_half;
    on_m1  = half_c - MIN_HALF;
  end
endmodule

// File: rtl/hb_phase_ctl.sv
module hb_phase_ctl
  import hb_gate_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int DEAD  = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PER_W-1:0] half_per,
  output phase_t           cur_ph,
  output phase_t           nxt_ph
);
  localparam logic [PER_W-1:0] GAP_M1 = PER_W'(DEAD - 1);

  phase_t           state_q;
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] per_q;
  logic             at_zero;
  logic             new_cycle;
  logic [PER_W-1:0] len_src;
  logic [PER_W-1:0] half_c;
  logic [PER_W-1:0] on_m1;

  assign at_zero   = (cnt_q == '0);
  assign new_cycle = en && ((state_q == PH_IDLE) ||
                            (state_q == PH_GAP_B && at_zero));
  assign len_src   = new_cycle ? half_per : per_q;

  hb_len_calc #(.PER_W(PER_W), .DEAD(DEAD)) u_len (
    .raw_half (len_src),
    .half_c   (half_c),
    .on_m1    (on_m1)
  );

  always_comb begin
    nxt_ph = state_q;
    if (!en) begin
      nxt_ph = PH_IDLE;
    end else begin
      case (state_q)
        PH_IDLE:  nxt_ph = PH_LS_ON;
        PH_LS_ON: if (at_zero) nxt_ph = PH_GAP_A;
        PH_GAP_A: if (at_zero) nxt_ph = PH_HS_ON;
        PH_HS_ON: if (at_zero) nxt_ph = PH_GAP_B;
        PH_GAP_B: if (at_zero) nxt_ph = PH_LS_ON;
        default:  nxt_ph = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      per_q   <= '0;
    end else begin
      state_q <= nxt_ph;
      if (new_cycle) per_q <= half_c;
      if (nxt_ph != state_q) begin
        case (nxt_ph)
          PH_LS_ON, PH_HS_ON: cnt_q <= on_m1;
          PH_GAP_A, PH_GAP_B: cnt_q <= GAP_M1;
          default:            cnt_q <= '0;
        endcase
      end else if (!at_zero) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign cur_ph = state_q;
endmodule

// File: rtl/hb_out_reg.sv
module hb_out_reg
  import hb_gate_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_t cur_ph,
  input  phase_t nxt_ph,
  output logic   hs_q,
  output logic   ls_q,
  output logic   rise_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q   <= 1'b0;
      ls_q   <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      hs_q   <= (nxt_ph == PH_HS_ON);
      ls_q   <= (nxt_ph == PH_LS_ON);
      rise_q <= (nxt_ph == PH_LS_ON) && (cur_ph != PH_LS_ON);
    end
  end
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
  import hb_gate_pkg::*;
#(
  parameter int PER_W     = 16,
  parameter int CLK_MHZ   = 50,
  parameter bit SLOW_DEAD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [PER_W-1:0] half_per,
  output logic             hs_gate,
  output logic             ls_gate,
  output logic             ls_rise
);
  localparam int DEAD_CYC = dead_cycles(CLK_MHZ, SLOW_DEAD);

  phase_t cur_ph;
  phase_t nxt_ph;

  hb_phase_ctl #(.PER_W(PER_W), .DEAD(DEAD_CYC)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .half_per (half_per),
    .cur_ph   (cur_ph),
    .nxt_ph   (nxt_ph)
  );

  hb_out_reg u_out (
    .clk    (clk),
    .rst    (rst),
    .cur_ph (cur_ph),
    .nxt_ph (nxt_ph),
    .hs_q   (hs_gate),
    .ls_q   (ls_gate),
    .rise_q (ls_rise)
  );
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
  parameter int DEAD = 9
) (
  input logic clk,
  input logic rst,
  input logic en,
  input logic hs_gate,
  input logic ls_gate,
  input logic ls_rise
);
  logic [15:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst || hs_gate || ls_gate) gap_q <= '0;
    else if (gap_q != 16'hFFFF)    gap_q <= gap_q + 1'b1;
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(hs_gate && ls_gate)); // R6

  AST_OFF_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hs_gate && !ls_gate)); // R7

  AST_STROBE_EDGE: assert property (@(posedge clk) disable iff (rst)
    ls_rise == $rose(ls_gate)); // R9

  AST_LOW_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(en) |=> (ls_gate && !hs_gate)); // R3

  AST_HS_DEAD_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(hs_gate) |-> (gap_q == 16'(DEAD))); // R4
endmodule

bind hb_gate_seq hb_gate_seq_chk #(.DEAD(DEAD_CYC)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .hs_gate (hs_gate),
  .ls_gate (ls_gate),
  .ls_rise (ls_rise)
);

// File: tb/sim_hb_gate_seq.sv
module sim_hb_gate_seq;
  localparam int PER_W = 16;
  localparam int DEAD0 = 9;
  localparam int DEAD1 = 5;

  typedef struct {
    logic [2:0] v0;
    logic [2:0] v1;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [PER_W-1:0] half_per = '0;
  logic hs0, ls0, st0, hs1, ls1, st1;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  exp_t q[$];

  int pos [2] = '{-1, -1};
  int hcur[2] = '{0, 0};

  always #10 clk = ~clk;

  hb_gate_seq #(.PER_W(PER_W), .CLK_MHZ(5), .SLOW_DEAD(1'b1)) u0 (
    .clk(clk), .rst(rst), .en(en), .half_per(half_per),
    .hs_gate(hs0), .ls_gate(ls0), .ls_rise(st0));

  hb_gate_seq #(.PER_W(PER_W), .CLK_MHZ(5), .SLOW_DEAD(1'b0)) u1 (
    .clk(clk), .rst(rst), .en(en), .half_per(half_per),
    .hs_gate(hs1), .ls_gate(ls1), .ls_rise(st1));

  function automatic logic [2:0] model(int k, bit e, int h, int dead);
    int on;
    if (!e) begin
      pos[k] = -1;
      return 3'b000;
    end
    if (pos[k] < 0 || pos[k] + 1 >= 2 * hcur[k]) begin
      hcur[k] = (h < dead + 1) ? dead + 1 : h;
      pos[k]  = 0;
    end else begin
      pos[k] = pos[k] + 1;
    end
    on = hcur[k] - dead;
    // {hs, ls, strobe}
    return {(pos[k] >= hcur[k] && pos[k] < hcur[k] + on),
            (pos[k] < on), (pos[k] == 0)};
  endfunction

  task automatic step(bit e, int h, string tag);
    exp_t x;
    @(negedge clk);
    en       = e;
    half_per = PER_W'(h);
    x.v0  = model(0, e, h, DEAD0);
    x.v1  = model(1, e, h, DEAD1);
    x.tag = tag;
    q.push_back(x);
  endtask

  task automatic run(bit e, int h, int n, string tag);
    for (int i = 0; i < n; i++) step(e, h, tag);
  endtask

  task automatic cmp(string tag, logic [2:0] act, logic [2:0] exp, string who);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s {hs,ls,rise} actual=%b expected=%b at %0t",
               tag, who, act, exp, $time);
    end
  endtask

  // monitor: compares outputs settled after each edge
  initial begin
    exp_t x;
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        x = q.pop_front();
        cmp(x.tag, {hs0, ls0, st0}, x.v0, "u0");
        cmp(x.tag, {hs1, ls1, st1}, x.v1, "u1");
        cmp("R6", {1'b0, hs0 & ls0, hs1 & ls1}, 3'b000, "both");
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    cmp("R1", {hs0, ls0, st0}, 3'b000, "u0 reset");
    cmp("R1", {hs1, ls1, st1}, 3'b000, "u1 reset");
    rst = 1'b0;
    run(1'b0, 25, 6, "R2 disabled");
    run(1'b0, 3, 6, "R2 disabled");
    run(1'b1, 20, 130, "R3 R4 R5 R9");
    run(1'b1, 20, 7, "R8 before change");
    run(1'b1, 30, 150, "R8 new period");
    run(1'b0, 30, 8, "R7 disable mid-cycle");
    run(1'b1, 14, 90, "R3 restart");
    run(1'b1, 3, 60, "R10 clamp");
    run(1'b1, 8, 60, "R10 clamp u0 only");
    run(1'b1, 17, 23, "R5 odd half");
    run(1'b0, 17, 5, "R7 disable");
    run(1'b1, 12, 70, "R3 R9 restart");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule